// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Queue

This block holds a short list of DMA descriptors for a storage-card data mover. Software builds each descriptor in two register writes. The first write loads a 64-bit bus address into a staging register. The second writes a 64-bit command word, and that write commits the staged address and the command together as one queue entry. A combined control/status register controls the queue. Through it software flushes and disables the queue, reads the number of entries still outstanding, sets a refill threshold, enables the interrupt and clears sticky status.

The engine side takes entries in arrival order over a valid/ready handshake. For each entry it sees:
- the address;
- the transfer length, already converted to bytes;
- the direction;
- the byte-swap and little-endian selects;
- whether the entry should interrupt on completion.

The engine later returns one completion pulse for each entry it has taken. An entry stays counted until its completion pulse arrives, so the occupancy count covers entries waiting for the engine and entries the engine is still moving.

Top module: `sgq_desc_queue`

## Requirements
- R1: After reset the control register reads 0x0001_0000: the clear bit (16) is 1 and every other field is 0. `pop_valid` and `irq_o` are 0.
- R2: A write to offset 0x10 stages an address. A write to offset 0x18 commits the staged address and the command word as one entry, and the count in control bits 4:0 rises by one.
- R3: A command write is dropped when the queue already holds DEPTH (16) entries or the clear bit is 1. The dropped write sets sticky overflow bit 25, even if a completion arrives in the same cycle.
- R4: Entries reach the engine in first-in, first-out order. Each `pop_valid && pop_ready` cycle hands over one entry. For that entry:
  - `pop_dir` is command bit 62;
  - `pop_swap` is command bits {59,58,57};
  - `pop_le` is command bit 56;
  - `pop_irq_en` is the inverse of command bit 60.
- R5: `pop_len` equals (command bits 55:36 + 1) * 8 bytes. The largest value, 20'hFFFFF, gives 8 MiB.
- R6: A command write whose staged address has any of bits 2:0 set is not queued, and it sets sticky error bit 26. The count is unchanged.
- R7: A `done_i` pulse retires the oldest entry and decrements the count, but only when some entry has been handed to the engine and not yet retired. Otherwise the pulse is ignored.
- R8: Retiring an entry whose command bit 60 is 0 sets sticky completion bit 24. Retiring an entry whose bit 60 is 1 leaves bit 24 unchanged.
- R9: `irq_o` is 1 exactly when enable bit 20 is 1 and either bit 24 is 1, or the queue is enabled, level bits 12:8 are nonzero and the count is below that level.
- R10: Writing 1 to bits 24, 25 or 26 of the control register clears that bit, and writing 0 leaves it. A set event in the same cycle wins over the clear.
- R11: Writing the control register with bit 16 set empties the queue at that clock edge. While bit 16 is 1, `pop_valid` is 0 and `done_i` is ignored. Writing bit 16 as 0 enables the queue.
- R12: `reg_rdata` is registered. One cycle after `reg_addr` is presented it shows the control view for 0x00, the staged address for 0x10, and 0 for any other offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for writes and reads |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data |
| pop_valid | output | 1 | An unissued entry is offered to the engine |
| pop_ready | input | 1 | Engine takes the offered entry |
| pop_addr | output | 64 | Entry bus address |
| pop_len | output | 24 | Entry length in bytes |
| pop_dir | output | 1 | 1 = transfer toward the card |
| pop_swap | output | 3 | Swap selects {32-bit, 16-bit, 8-bit} |
| pop_le | output | 1 | Little-endian ordering select |
| pop_irq_en | output | 1 | Completion of this entry may interrupt |
| done_i | input | 1 | Completion pulse for the oldest issued entry |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench first targets the boundary at sixteen entries. A design that compares against the wrong fill level either accepts a seventeenth entry or rejects the sixteenth, and the model catches both through the count field and the overflow bit. It also sends completion pulses while nothing has been issued, and while the queue is cleared. A design that retires on every pulse drives the count below the number of queued entries, and then hands out the wrong head entry. The bench also checks that the suppress flag is honoured only for the entry being retired, that a misaligned push is refused and does not simply queue, and that a flush takes effect on the edge of the write itself and not one cycle later. Each of these mistakes shows up as a mismatch in `reg_rdata`, `pop_valid` or `irq_o` within a cycle.

// File: rtl/sgq_pkg.sv
package sgq_pkg;
  // Register offsets from the block base
  localparam logic [7:0] OFF_CFG = 8'h00;
  localparam logic [7:0] OFF_ADR = 8'h10;
  localparam logic [7:0] OFF_CMD = 8'h18;

  // Control register bit positions
  localparam int CFG_CLR  = 16;
  localparam int CFG_LVL  = 8;
  localparam int LVL_W    = 5;
  localparam int CFG_IEN  = 20;
  localparam int CFG_DONE = 24;
  localparam int CFG_OVF  = 25;
  localparam int CFG_MIS  = 26;

  // Command word bit positions
  localparam int CMD_DIR  = 62;
  localparam int CMD_SUPP = 60;
  localparam int CMD_SWAP = 57;
  localparam int CMD_LE   = 56;
  localparam int CMD_WRDS = 36;
  localparam int WORDS_W  = 20;

  typedef struct packed {
    logic [63:0]        addr;
    logic               dir;
    logic               supp;
    logic [2:0]         swap;
    logic               le;
    logic [WORDS_W-1:0] words;
  } sgq_entry_t;
endpackage

// File: rtl/sgq_regs.sv
module sgq_regs
  import sgq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [63:0]      reg_wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             full,
  input  logic             done_set,
  output logic [63:0]      reg_rdata,
  output logic             clr_q,
  output logic             flush,
  output logic             push,
  output sgq_entry_t       push_ent,
  output logic             irq_en_q,
  output logic             ovf_q,
  output logic             irq_o
);
  logic             cfg_wr, adr_wr, cmd_wr;
  logic [LVL_W-1:0] lvl_q;
  logic             dsts_q, mis_q;
  logic [63:0]      staged_q;
  logic [63:0]      cfg_view, rd_mux;
  logic             ovf_set, mis_set;
  logic             unused_cmd_bits;

  assign cfg_wr = reg_wr && (reg_addr == OFF_CFG);
  assign adr_wr = reg_wr && (reg_addr == OFF_ADR);
  assign cmd_wr = reg_wr && (reg_addr == OFF_CMD);

  // Commit rules: disabled or full beats misalignment
  assign ovf_set = cmd_wr && (clr_q || full);
  assign mis_set = cmd_wr && !clr_q && !full && (staged_q[2:0] != 3'b000);
  assign push    = cmd_wr && !clr_q && !full && (staged_q[2:0] == 3'b000);
  assign flush   = clr_q || (cfg_wr && reg_wdata[CFG_CLR]);

  assign push_ent.addr  = staged_q;
  assign push_ent.dir   = reg_wdata[CMD_DIR];
  assign push_ent.supp  = reg_wdata[CMD_SUPP];
  assign push_ent.swap  = reg_wdata[CMD_SWAP+2:CMD_SWAP];
  assign push_ent.le    = reg_wdata[CMD_LE];
  assign push_ent.words = reg_wdata[CMD_WRDS+WORDS_W-1:CMD_WRDS];
  assign unused_cmd_bits = ^{reg_wdata[63], reg_wdata[61], reg_wdata[35:27],
                             reg_wdata[23:21], reg_wdata[19:17], reg_wdata[15:13],
                             reg_wdata[7:0]};

  always_comb begin
    cfg_view = '0;
    cfg_view[CNT_W-1:0]             = cnt;
    cfg_view[CFG_LVL+LVL_W-1:CFG_LVL] = lvl_q;
    cfg_view[CFG_CLR]               = clr_q;
    cfg_view[CFG_IEN]               = irq_en_q;
    cfg_view[CFG_DONE]              = dsts_q;
    cfg_view[CFG_OVF]               = ovf_q;
    cfg_view[CFG_MIS]               = mis_q;
  end

  always_comb begin
    case (reg_addr)
      OFF_CFG: rd_mux = cfg_view;
      OFF_ADR: rd_mux = staged_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_q     <= 1'b1;
      lvl_q     <= '0;
      irq_en_q  <= 1'b0;
      dsts_q    <= 1'b0;
      ovf_q     <= 1'b0;
      mis_q     <= 1'b0;
      staged_q  <= '0;
      reg_rdata <= '0;
    end else begin
      reg_rdata <= rd_mux;
      if (adr_wr) staged_q <= reg_wdata;
      if (cfg_wr) begin
        clr_q    <= reg_wdata[CFG_CLR];
        lvl_q    <= reg_wdata[CFG_LVL+LVL_W-1:CFG_LVL];
        irq_en_q <= reg_wdata[CFG_IEN];
      end
      dsts_q <= (dsts_q && !(cfg_wr && reg_wdata[CFG_DONE])) || done_set;
      ovf_q  <= (ovf_q  && !(cfg_wr && reg_wdata[CFG_OVF]))  || ovf_set;
      mis_q  <= (mis_q  && !(cfg_wr && reg_wdata[CFG_MIS]))  || mis_set;
    end
  end

  assign irq_o = irq_en_q && (dsts_q ||
                 (!clr_q && (lvl_q != '0) && (int'(cnt) < int'(lvl_q))));
endmodule

// File: rtl/sgq_store.sv
module sgq_store
  import sgq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             en,
  input  logic             push,
  input  sgq_entry_t       push_ent,
  input  logic             pop_ready,
  input  logic             done_i,
  output logic             pop_valid,
  output sgq_entry_t       head_ent,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] pend,
  output logic             full,
  output logic             done_set
);
  sgq_entry_t      mem [DEPTH];
  logic [AW-1:0]   wr_ptr, is_ptr, rt_ptr;
  logic            pop_fire, retire;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  // Storage without reset so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_ent;
  end

  assign head_ent  = mem[is_ptr];
  assign full      = (cnt == CNT_W'(DEPTH));
  assign pop_valid = en && (pend != '0);
  assign pop_fire  = pop_valid && pop_ready;
  assign retire    = done_i && en && !flush && (cnt != pend);
  assign done_set  = retire && !mem[rt_ptr].supp;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      is_ptr <= '0;
      rt_ptr <= '0;
      cnt    <= '0;
      pend   <= '0;
    end else begin
      if (push)     wr_ptr <= nxt(wr_ptr);
      if (pop_fire) is_ptr <= nxt(is_ptr);
      if (retire)   rt_ptr <= nxt(rt_ptr);
      cnt  <= cnt  + CNT_W'(push) - CNT_W'(retire);
      pend <= pend + CNT_W'(push) - CNT_W'(pop_fire);
    end
  end
endmodule

// File: rtl/sgq_desc_queue.sv
module sgq_desc_queue
  import sgq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = WORDS_W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [63:0]      reg_wdata,
  output logic [63:0]      reg_rdata,
  output logic             pop_valid,
  input  logic             pop_ready,
  output logic [63:0]      pop_addr,
  output logic [LEN_W-1:0] pop_len,
  output logic             pop_dir,
  output logic [2:0]       pop_swap,
  output logic             pop_le,
  output logic             pop_irq_en,
  input  logic             done_i,
  output logic             irq_o
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic             clr_q, flush, push, full, done_set, irq_en_q, ovf_q;
  logic [CNT_W-1:0] cnt, pend;
  sgq_entry_t       push_ent, head_ent;

  sgq_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cnt(cnt), .full(full), .done_set(done_set),
    .reg_rdata(reg_rdata), .clr_q(clr_q), .flush(flush), .push(push),
    .push_ent(push_ent), .irq_en_q(irq_en_q), .ovf_q(ovf_q), .irq_o(irq_o)
  );

  sgq_store #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) store_i (
    .clk(clk), .rst(rst), .flush(flush), .en(!clr_q), .push(push),
    .push_ent(push_ent), .pop_ready(pop_ready), .done_i(done_i),
    .pop_valid(pop_valid), .head_ent(head_ent), .cnt(cnt), .pend(pend),
    .full(full), .done_set(done_set)
  );

  assign pop_addr   = head_ent.addr;
  assign pop_len    = (LEN_W'(head_ent.words) + LEN_W'(1)) << 3;
  assign pop_dir    = head_ent.dir;
  assign pop_swap   = head_ent.swap;
  assign pop_le     = head_ent.le;
  assign pop_irq_en = !head_ent.supp;
endmodule

// File: rtl/sgq_checks.sv
module sgq_checks
  import sgq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int LEN_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [7:0]       reg_addr,
  input logic [63:0]      reg_wdata,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] pend,
  input logic             clr_q,
  input logic             irq_en_q,
  input logic             ovf_q,
  input logic             pop_valid,
  input logic [LEN_W-1:0] pop_len,
  input logic             irq_o
);
  // R3: occupancy never exceeds the depth
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= DEPTH);

  // R3: overflow only rises after a command write
  p_ovf_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> $past(reg_wr && reg_addr == OFF_CMD));

  // R7: issued-but-unretired entries cannot be negative
  p_pend_le_cnt_r7: assert property (@(posedge clk) disable iff (rst)
    pend <= cnt);

  // R11: cleared queue offers nothing
  p_no_pop_cleared_r11: assert property (@(posedge clk) disable iff (rst)
    clr_q |-> !pop_valid);

  // R11: flush empties on the write edge
  p_flush_empties_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OFF_CFG && reg_wdata[CFG_CLR]) |=> (cnt == '0));

  // R5: byte length is a nonzero multiple of eight
  p_len_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> (pop_len[2:0] == 3'b000 && pop_len != '0));

  // R9: interrupt never fires without its enable
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> irq_en_q);
endmodule

bind sgq_desc_queue sgq_checks #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cnt(cnt), .pend(pend), .clr_q(clr_q),
  .irq_en_q(irq_en_q), .ovf_q(ovf_q), .pop_valid(pop_valid),
  .pop_len(pop_len), .irq_o(irq_o)
);

// File: tb/sgq_desc_queue_tb_top.sv
module sgq_desc_queue_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        pop_valid, pop_ready = 1'b0;
  logic [63:0] pop_addr;
  logic [23:0] pop_len;
  logic        pop_dir, pop_le, pop_irq_en, irq_o;
  logic [2:0]  pop_swap;
  logic        done_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sgq_desc_queue dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pop_valid(pop_valid),
    .pop_ready(pop_ready), .pop_addr(pop_addr), .pop_len(pop_len),
    .pop_dir(pop_dir), .pop_swap(pop_swap), .pop_le(pop_le),
    .pop_irq_en(pop_irq_en), .done_i(done_i), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { logic [63:0] addr; logic [63:0] cmd; } ent_t;
  ent_t        mq[$];
  int          m_pend;
  bit          m_clr, m_en, m_dsts, m_ovf, m_mis;
  int          m_lvl;
  logic [63:0] m_staged, m_rdata;

  function automatic logic [63:0] view(input logic [7:0] a);
    logic [63:0] v;
    v = '0;
    if (a == 8'h00) begin
      v = 64'(mq.size()) | (64'(m_lvl) << 8) | (64'(m_clr) << 16) |
          (64'(m_en) << 20) | (64'(m_dsts) << 24) | (64'(m_ovf) << 25) |
          (64'(m_mis) << 26);
    end else if (a == 8'h10) v = m_staged;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); m_pend = 0; m_clr = 1; m_en = 0; m_dsts = 0;
      m_ovf = 0; m_mis = 0; m_lvl = 0; m_staged = '0; m_rdata = '0;
    end else begin
      bit cfgw, adrw, cmdw, ret, popf, full0, dset, oset, mset;
      int issued;
      m_rdata = view(reg_addr);
      cfgw = reg_wr && reg_addr == 8'h00;
      adrw = reg_wr && reg_addr == 8'h10;
      cmdw = reg_wr && reg_addr == 8'h18;
      issued = mq.size() - m_pend;
      full0 = mq.size() >= 16;
      ret  = done_i && !m_clr && issued > 0 && !(cfgw && reg_wdata[16]);
      popf = !m_clr && m_pend > 0 && pop_ready;
      dset = 0; oset = 0; mset = 0;
      if (ret) begin
        dset = !mq[0].cmd[60];
        void'(mq.pop_front());
      end
      if (popf) m_pend--;
      if (cmdw) begin
        if (m_clr || full0) oset = 1;
        else if (m_staged[2:0] != 0) mset = 1;
        else begin mq.push_back('{m_staged, reg_wdata}); m_pend++; end
      end
      m_dsts = (m_dsts && !(cfgw && reg_wdata[24])) || dset;
      m_ovf  = (m_ovf  && !(cfgw && reg_wdata[25])) || oset;
      m_mis  = (m_mis  && !(cfgw && reg_wdata[26])) || mset;
      if (cfgw) begin
        m_clr = reg_wdata[16]; m_en = reg_wdata[20]; m_lvl = int'(reg_wdata[12:8]);
        if (reg_wdata[16]) begin mq.delete(); m_pend = 0; end
      end
      if (adrw) m_staged = reg_wdata;
    end
  end

  // compare every cycle, away from the edge
  always @(posedge clk) begin
    #1;
    if (!rst && !finished) begin
      bit ev, ei;
      ev = !m_clr && m_pend > 0;
      ei = m_en && (m_dsts || (!m_clr && m_lvl != 0 && mq.size() < m_lvl));
      chk("R12 rdata", reg_rdata, m_rdata);
      chk("R4 pop_valid", 64'(pop_valid), 64'(ev));
      chk("R9 irq", 64'(irq_o), 64'(ei));
      if (ev) begin
        ent_t h;
        h = mq[mq.size() - m_pend];
        chk("R4 addr", pop_addr, h.addr);
        chk("R5 len", 64'(pop_len), (64'(h.cmd[55:36]) + 1) * 8);
        chk("R4 dir", 64'(pop_dir), 64'(h.cmd[62]));
        chk("R4 swap", 64'(pop_swap), 64'(h.cmd[59:57]));
        chk("R4 le", 64'(pop_le), 64'(h.cmd[56]));
        chk("R4 irq_en", 64'(pop_irq_en), 64'(!h.cmd[60]));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 8'h00;
  endtask

  task automatic push(input logic [63:0] a, input logic [63:0] c);
    wr(8'h10, a);
    wr(8'h18, c);
  endtask

  task automatic pulse_done();
    @(negedge clk); done_i = 1'b1;
    @(posedge clk); #1; done_i = 1'b0;
  endtask

  task automatic rd_cfg(output logic [63:0] v);
    @(negedge clk); reg_addr = 8'h00;
    @(posedge clk); #1; v = reg_rdata;
  endtask

  function automatic logic [63:0] mk(input bit dir, input bit supp, input logic [2:0] sw,
                                     input bit le, input logic [19:0] w);
    return (64'(dir) << 62) | (64'(supp) << 60) | (64'(sw) << 57) | (64'(le) << 56) |
           (64'(w) << 36);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    rd_cfg(v);
    chk("R1 reset cfg", v, 64'h0001_0000);
    chk("R1 reset pop_valid", 64'(pop_valid), 0);
    chk("R1 reset irq", 64'(irq_o), 0);

    // R3: push while cleared
    push(64'h100, mk(0, 0, 0, 0, 1));
    rd_cfg(v);
    chk("R3 ovf when cleared", 64'(v[25]), 1);
    chk("R3 nothing queued", 64'(v[4:0]), 0);
    wr(8'h00, 64'h0201_0000);
    rd_cfg(v);
    chk("R10 ovf W1C", 64'(v[25]), 0);

    // enable, three entries held back
    wr(8'h00, 64'h0);
    push(64'h1000, mk(1, 1, 3'b101, 1, 20'd5));
    push(64'h2008, mk(0, 0, 3'b010, 0, 20'd0));
    push(64'h3000, mk(1, 0, 3'b000, 1, 20'hFFFFF));
    rd_cfg(v);
    chk("R2 count three", 64'(v[4:0]), 3);
    chk("R4 head addr", pop_addr, 64'h1000);
    chk("R5 head len", 64'(pop_len), 48);
    chk("R4 head swap", 64'(pop_swap), 5);
    @(negedge clk); reg_addr = 8'h10;
    @(posedge clk); #1;
    chk("R12 staged readback", reg_rdata, 64'h3000);
    @(negedge clk); reg_addr = 8'h00;

    // R6: misaligned
    push(64'h4004, mk(0, 0, 0, 0, 2));
    rd_cfg(v);
    chk("R6 misalign flag", 64'(v[26]), 1);
    chk("R6 count unchanged", 64'(v[4:0]), 3);

    // R7: done with nothing issued
    pulse_done();
    rd_cfg(v);
    chk("R7 stray done ignored", 64'(v[4:0]), 3);

    // issue all three
    @(negedge clk); pop_ready = 1'b1;
    repeat (4) @(negedge clk);
    pop_ready = 1'b0;
    chk("R4 all issued", 64'(pop_valid), 0);
    pulse_done();
    rd_cfg(v);
    chk("R8 suppressed entry", 64'(v[24]), 0);
    chk("R7 count after retire", 64'(v[4:0]), 2);
    pulse_done();
    rd_cfg(v);
    chk("R8 completion flag", 64'(v[24]), 1);
    chk("R9 irq off without enable", 64'(irq_o), 0);
    wr(8'h00, 64'h0010_0000);
    chk("R9 irq on", 64'(irq_o), 1);
    wr(8'h00, 64'h0110_0000);
    chk("R10 done W1C drops irq", 64'(irq_o), 0);
    pulse_done();
    wr(8'h00, 64'h0100_0000);

    // R3: fill to 16 and overflow
    for (int i = 0; i < 17; i++) push(64'(i) << 3, mk(0, 1, 0, 0, 20'(i)));
    rd_cfg(v);
    chk("R3 full count", 64'(v[4:0]), 16);
    chk("R3 overflow at 17", 64'(v[25]), 1);
    wr(8'h00, 64'h0201_0000);
    rd_cfg(v);
    chk("R11 flush count", 64'(v[4:0]), 0);
    chk("R11 flush pop_valid", 64'(pop_valid), 0);

    // R9: level interrupt
    wr(8'h00, 64'h0010_0400);
    chk("R9 level irq", 64'(irq_o), 1);
    for (int i = 0; i < 4; i++) push(64'h8000, mk(0, 1, 0, 0, 1));
    chk("R9 level met", 64'(irq_o), 0);
    wr(8'h00, 64'h0001_0000);
    wr(8'h00, 64'h0);

    // mixed traffic against the model
    for (int c = 0; c < 6000; c++) begin
      int op;
      @(negedge clk);
      op = int'($urandom % 16);
      reg_wr = 1'b0; done_i = 1'b0;
      pop_ready = 1'($urandom % 2);
      reg_addr = 8'(($urandom % 4) * 8'h08 * 2);
      if (op < 4) begin
        reg_wr = 1'b1; reg_addr = 8'h10;
        reg_wdata = {$urandom, $urandom} & (($urandom % 8 == 0) ? 64'hFFFF : 64'hFFF8);
      end else if (op < 8) begin
        reg_wr = 1'b1; reg_addr = 8'h18; reg_wdata = {$urandom, $urandom};
      end else if (op < 11) begin
        done_i = 1'b1;
      end else if (op == 11) begin
        reg_wr = 1'b1; reg_addr = 8'h00;
        reg_wdata = (64'($urandom % 6 == 0) << 16) | (64'($urandom % 2) << 20) |
                    (64'($urandom % 32) << 8) | (64'($urandom % 8) << 24);
      end
    end
    @(negedge clk); reg_wr = 1'b0; done_i = 1'b0; pop_ready = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule